// File: doc/BRIEF.md
# Debug Port Bring-Up Sequencer

This controller runs the fixed start-up script of a serial-wire debug port after a start pulse. It does no wire-level shifting itself. Every step goes out as one request on a request/response interface to a separate transaction engine. A request is a turnaround cycle, a raw burst of up to 32 line bits, or a register read or write on the debug port (DP) or an access port (AP). The engine answers each request with a 3-bit acknowledge and, for reads, a 32-bit data word.

The script does the following, in order:
- Puts the line in a known state and sends the JTAG-to-SWD switch pattern.
- Reads and checks the part identification.
- Asks for system and debug power-up, then polls a bounded number of times for both acknowledges.
- Confirms that access port 0 is a memory-bus port.
- Programs that port's control word for 32-bit accesses with auto-increment.

Before an AP access whose register bank differs from the cached bank selection, the block writes the DP bank-select register first. The cache is invalidated at every start. When the script completes, or when any step fails, the block holds `done` and a 3-bit code. The code is 0 on success; otherwise it names the step that failed.

Top module: `dbg_bringup_seq`

## Requirements
- R1: After reset, busy, done, req_valid and err_code are all 0.
- R2: After start, the first request is a turnaround (req_kind 0). Then come raw line writes (req_kind 1, LSB first, req_nbits gives the bit count), in this order: 0xFFFFFFFF/32 twice, 0x0000E79E/16, 0xFFFFFFFF/32 twice, 0x00000000/32 twice.
- R3: While req_valid is high and req_ready is low, every request field stays unchanged. After a handshake, no new request is raised until rsp_valid has returned the response.
- R4: The identification is read as a DP read (req_kind 2, req_ap 0, req_addr 0, which is bits 3:2 of the register address). An acknowledge other than 3'b001 ends the run with err_code 1.
- R5: The identification is accepted only when (data & 0x0FF00001) == 0x0BA00001. Any other value ends the run with err_code 2.
- R6: Power-up is requested by a DP write (req_kind 3) to req_addr 1 with data 0x50000000. A failed acknowledge ends the run with err_code 3.
- R7: DP req_addr 1 is then read at most 4 times. The script continues as soon as data bits 31 and 29 are both set. A read whose acknowledge is not 3'b001 ends the run with code 4. Four reads without both bits set end it with code 5.
- R8: The AP identity is checked in two steps. First comes a DP write to req_addr 2 (bank select) with 0x000000F0. Then comes an AP read (req_ap 1) at req_addr 3. A data low nibble other than 1, or a failed acknowledge on either request, gives err_code 6.
- R9: The control word is written in two steps. First comes a bank-select write with 0x00000000. Then comes an AP write at req_addr 0 with 0x00000052. A failed acknowledge gives err_code 7. On success, done is raised with err_code 0.
- R10: done and err_code hold until the next start, and no request is raised while done is high. A start pulse during a run is ignored. A start after done reruns the whole script, including the bank-select writes.
- R11: On raw writes and turnarounds the acknowledge is not checked. Reads and turnarounds carry req_wdata 0. All register requests carry req_nbits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse for the bring-up script |
| busy | output | 1 | Script in progress |
| done | output | 1 | Script finished (success or error) |
| err_code | output | 3 | 0 = success, 1..7 = failing step |
| req_valid | output | 1 | Request to the transaction engine is valid |
| req_ready | input | 1 | Engine accepts the request |
| req_kind | output | 2 | 0 turnaround, 1 raw write, 2 register read, 3 register write |
| req_ap | output | 1 | 1 = access port, 0 = debug port |
| req_addr | output | 2 | Register address bits 3:2 |
| req_wdata | output | 32 | Write data or raw line bits |
| req_nbits | output | 6 | Raw bit count (0 for other kinds) |
| rsp_valid | input | 1 | Response from the engine is valid |
| rsp_ack | input | 3 | Acknowledge, 3'b001 = OK |
| rsp_data | input | 32 | Read data |

## Verification
The hardest case to reach is the poll boundary. Bits 31 and 29 must first appear on exactly the fourth read, which has to pass. No acknowledge on any of the four reads has to give code 5. The bench's engine model counts the poll reads and returns the acknowledge bits only from a configurable poll index onward, so both sides of the limit are reached. Failures at each other step are injected by setting that step's acknowledge or data in the model. A scoreboard then confirms that the request stream stops exactly at the failing step. A second run back to back checks that the bank-select cache was invalidated.

// File: rtl/dbg_bringup_pkg.sv
package dbg_bringup_pkg;
  localparam int DATA_W  = 32;
  localparam int NBITS_W = 6;
  localparam int N_STEPS = 13;
  localparam int STEP_W  = $clog2(N_STEPS);

  typedef enum logic [1:0] {
    K_TURN = 2'd0,
    K_RAW  = 2'd1,
    K_RD   = 2'd2,
    K_WR   = 2'd3
  } kind_e;

  typedef enum logic [2:0] {
    C_NONE = 3'd0,
    C_OK   = 3'd1,
    C_ID   = 3'd2,
    C_PWR  = 3'd3,
    C_APT  = 3'd4
  } chk_e;

  typedef struct packed {
    kind_e               kind;
    logic                ap;
    logic [1:0]          reg_a;
    logic [3:0]          bank;
    logic [DATA_W-1:0]   wdata;
    logic [NBITS_W-1:0]  nbits;
    chk_e                chk;
    logic [2:0]          ecode_xfer;
    logic [2:0]          ecode_chk;
  } step_t;

  localparam logic [2:0] E_NONE     = 3'd0;
  localparam logic [2:0] E_NO_TGT   = 3'd1;
  localparam logic [2:0] E_PART     = 3'd2;
  localparam logic [2:0] E_PWR_REQ  = 3'd3;
  localparam logic [2:0] E_PWR_RD   = 3'd4;
  localparam logic [2:0] E_PWR_TMO  = 3'd5;
  localparam logic [2:0] E_AP_TYPE  = 3'd6;
  localparam logic [2:0] E_AP_CTRL  = 3'd7;

  localparam logic [2:0] ACK_OK = 3'b001;
endpackage

// File: rtl/dbg_bringup_script.sv
module dbg_bringup_script
  import dbg_bringup_pkg::*;
(
  input  logic [STEP_W-1:0] idx,
  output step_t             step
);
  function automatic step_t mk(kind_e k, logic ap, logic [1:0] ra, logic [3:0] bk,
                               logic [DATA_W-1:0] wd, logic [NBITS_W-1:0] nb,
                               chk_e c, logic [2:0] ex, logic [2:0] ec);
    step_t s;
    s.kind = k; s.ap = ap; s.reg_a = ra; s.bank = bk; s.wdata = wd;
    s.nbits = nb; s.chk = c; s.ecode_xfer = ex; s.ecode_chk = ec;
    return s;
  endfunction

  localparam logic [DATA_W-1:0] ONES = '1;

  always_comb begin
    case (idx)
      4'd0:  step = mk(K_TURN, 1'b0, 2'd0, 4'h0, '0, '0, C_NONE, E_NONE, E_NONE);
      4'd1,
      4'd2,
      4'd4,
      4'd5:  step = mk(K_RAW, 1'b0, 2'd0, 4'h0, ONES, 6'd32, C_NONE, E_NONE, E_NONE);
      4'd3:  step = mk(K_RAW, 1'b0, 2'd0, 4'h0, 32'h0000_E79E, 6'd16, C_NONE, E_NONE, E_NONE);
      4'd6,
      4'd7:  step = mk(K_RAW, 1'b0, 2'd0, 4'h0, '0, 6'd32, C_NONE, E_NONE, E_NONE);
      4'd8:  step = mk(K_RD, 1'b0, 2'd0, 4'h0, '0, '0, C_ID, E_NO_TGT, E_PART);
      4'd9:  step = mk(K_WR, 1'b0, 2'd1, 4'h0, 32'h5000_0000, '0, C_OK, E_PWR_REQ, E_PWR_REQ);
      4'd10: step = mk(K_RD, 1'b0, 2'd1, 4'h0, '0, '0, C_PWR, E_PWR_RD, E_PWR_TMO);
      4'd11: step = mk(K_RD, 1'b1, 2'd3, 4'hF, '0, '0, C_APT, E_AP_TYPE, E_AP_TYPE);
      4'd12: step = mk(K_WR, 1'b1, 2'd0, 4'h0, 32'h0000_0052, '0, C_OK, E_AP_CTRL, E_AP_CTRL);
      default: step = mk(K_TURN, 1'b0, 2'd0, 4'h0, '0, '0, C_NONE, E_NONE, E_NONE);
    endcase
  end
endmodule

// File: rtl/dbg_sel_cache.sv
module dbg_sel_cache
  import dbg_bringup_pkg::*;
#(
  parameter int AP_INDEX = 0
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inval,
  input  logic              load,
  input  logic [3:0]        bank,
  output logic              need,
  output logic [DATA_W-1:0] sel_word
);
  logic [DATA_W-1:0] cache_q, cache_d;
  logic              cache_en;

  assign sel_word = {AP_INDEX[7:0], 16'h0000, bank, 4'h0};
  assign need     = (sel_word != cache_q);

  always_comb begin
    cache_en = inval | load;
    cache_d  = inval ? '1 : sel_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cache_q <= '1;
    else if (cache_en) cache_q <= cache_d;
  end
endmodule

// File: rtl/dbg_rsp_judge.sv
module dbg_rsp_judge
  import dbg_bringup_pkg::*;
(
  input  chk_e              chk,
  input  logic [2:0]        ack,
  input  logic [DATA_W-1:0] data,
  output logic              xfer_ok,
  output logic              cond_ok
);
  localparam logic [DATA_W-1:0] ID_MASK = 32'h0FF0_0001;
  localparam logic [DATA_W-1:0] ID_WANT = 32'h0BA0_0001;

  assign xfer_ok = (ack == ACK_OK);

  always_comb begin
    case (chk)
      C_ID:    cond_ok = ((data & ID_MASK) == ID_WANT);
      C_PWR:   cond_ok = data[31] & data[29];
      C_APT:   cond_ok = (data[3:0] == 4'd1);
      default: cond_ok = 1'b1;
    endcase
  end
endmodule

// File: rtl/dbg_bringup_seq.sv
module dbg_bringup_seq
  import dbg_bringup_pkg::*;
#(
  parameter int POLL_MAX = 4,
  parameter int AP_INDEX = 0
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  output logic               busy,
  output logic               done,
  output logic [2:0]         err_code,
  output logic               req_valid,
  input  logic               req_ready,
  output logic [1:0]         req_kind,
  output logic               req_ap,
  output logic [1:0]         req_addr,
  output logic [DATA_W-1:0]  req_wdata,
  output logic [NBITS_W-1:0] req_nbits,
  input  logic               rsp_valid,
  input  logic [2:0]         rsp_ack,
  input  logic [DATA_W-1:0]  rsp_data
);
  localparam int PCW = $clog2(POLL_MAX + 1);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(N_STEPS - 1);
  localparam logic [PCW-1:0]    POLL_LAST = PCW'(POLL_MAX - 1);

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_DONE} state_e;

  state_e            state_q, state_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic [PCW-1:0]    poll_q, poll_d;
  logic [2:0]        err_q, err_d;
  logic              step_en, poll_en, err_en;

  step_t             step;
  logic              sel_need, sel_load, sel_inval;
  logic [DATA_W-1:0] sel_word;
  logic              is_sel, xfer_ok, cond_ok;

  dbg_bringup_script u_script (.idx(step_q), .step(step));

  dbg_sel_cache #(.AP_INDEX(AP_INDEX)) u_sel (
    .clk(clk), .rst_n(rst_n), .inval(sel_inval), .load(sel_load),
    .bank(step.bank), .need(sel_need), .sel_word(sel_word)
  );

  dbg_rsp_judge u_judge (
    .chk(step.chk), .ack(rsp_ack), .data(rsp_data),
    .xfer_ok(xfer_ok), .cond_ok(cond_ok)
  );

  // A bank-select write is inserted ahead of an AP step whose bank is not cached
  assign is_sel = step.ap & sel_need;

  always_comb begin
    if (is_sel) begin
      req_kind  = K_WR;
      req_ap    = 1'b0;
      req_addr  = 2'd2;
      req_wdata = sel_word;
      req_nbits = '0;
    end else begin
      req_kind  = step.kind;
      req_ap    = step.ap;
      req_addr  = step.reg_a;
      req_wdata = step.wdata;
      req_nbits = step.nbits;
    end
  end

  assign req_valid = (state_q == S_ISSUE);
  assign busy      = (state_q == S_ISSUE) | (state_q == S_WAIT);
  assign done      = (state_q == S_DONE);
  assign err_code  = err_q;

  always_comb begin
    state_d   = state_q;
    step_d    = step_q;
    poll_d    = poll_q;
    err_d     = err_q;
    step_en   = 1'b0;
    poll_en   = 1'b0;
    err_en    = 1'b0;
    sel_load  = 1'b0;
    sel_inval = 1'b0;
    case (state_q)
      S_IDLE, S_DONE: begin
        if (start) begin
          state_d = S_ISSUE;
          step_d = '0;   step_en = 1'b1;
          poll_d = '0;   poll_en = 1'b1;
          err_d = E_NONE; err_en = 1'b1;
          sel_inval = 1'b1;
        end
      end
      S_ISSUE: begin
        if (req_ready) state_d = S_WAIT;
      end
      S_WAIT: begin
        if (rsp_valid) begin
          if (is_sel) begin
            if (xfer_ok) begin
              sel_load = 1'b1;
              state_d  = S_ISSUE;
            end else begin
              err_d = step.ecode_xfer; err_en = 1'b1;
              state_d = S_DONE;
            end
          end else if (step.chk != C_NONE && !xfer_ok) begin
            err_d = step.ecode_xfer; err_en = 1'b1;
            state_d = S_DONE;
          end else if (!cond_ok) begin
            if (step.chk == C_PWR && poll_q != POLL_LAST) begin
              poll_d = poll_q + 1'b1; poll_en = 1'b1;
              state_d = S_ISSUE;
            end else begin
              err_d = step.ecode_chk; err_en = 1'b1;
              state_d = S_DONE;
            end
          end else if (step_q == LAST_STEP) begin
            state_d = S_DONE;
          end else begin
            step_d = step_q + 1'b1; step_en = 1'b1;
            state_d = S_ISSUE;
          end
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      step_q  <= '0;
      poll_q  <= '0;
      err_q   <= E_NONE;
    end else begin
      state_q <= state_d;
      if (step_en) step_q <= step_d;
      if (poll_en) poll_q <= poll_d;
      if (err_en)  err_q  <= err_d;
    end
  end
endmodule

// File: rtl/dbg_bringup_seq_chk.sv
module dbg_bringup_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        busy,
  input logic        done,
  input logic [2:0]  err_code,
  input logic        req_valid,
  input logic        req_ready,
  input logic [1:0]  req_kind,
  input logic        req_ap,
  input logic [1:0]  req_addr,
  input logic [31:0] req_wdata,
  input logic [5:0]  req_nbits
);
  p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid &&
      $stable({req_kind, req_ap, req_addr, req_wdata, req_nbits}));

  p_one_outstanding_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_valid);

  p_first_turn_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> req_valid && req_kind == 2'd0);

  p_done_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !req_valid && !busy);

  p_err_with_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> err_code == 3'd0);

  p_run_needs_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  p_reg_nbits_r11: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_kind[1] |-> req_nbits == 6'd0);
endmodule

bind dbg_bringup_seq dbg_bringup_seq_chk u_chk (.*);

// File: tb/dbg_bringup_seq_test.sv
module dbg_bringup_seq_test;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n, start;
  logic        busy, done;
  logic [2:0]  err_code;
  logic        req_valid, req_ready;
  logic [1:0]  req_kind;
  logic        req_ap;
  logic [1:0]  req_addr;
  logic [31:0] req_wdata;
  logic [5:0]  req_nbits;
  logic        rsp_valid;
  logic [2:0]  rsp_ack;
  logic [31:0] rsp_data;

  dbg_bringup_seq uut (.*);

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, failures = 0;
  logic [42:0] exp_q[$];
  string       tag_q[$];

  // engine model configuration
  logic [2:0]  id_ack, pwr_ack, poll_ack, ap_ack, csw_ack;
  logic [31:0] id_val, idr_val;
  int          good_after, poll_seen, hold_cycles;

  task automatic check(bit ok, string tag, logic [42:0] act, logic [42:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [42:0] pack(logic [1:0] k, logic ap, logic [1:0] a,
                                       logic [31:0] w, logic [5:0] n);
    return {k, ap, a, w, n};
  endfunction

  task automatic push(logic [1:0] k, logic ap, logic [1:0] a, logic [31:0] w,
                      logic [5:0] n, string tag);
    exp_q.push_back(pack(k, ap, a, w, n));
    tag_q.push_back(tag);
  endtask

  // expected request stream, cut short at the failing step
  task automatic build(int stop_err, int npolls);
    push(2'd0, 0, 2'd0, 32'h0, 6'd0, "R2");
    push(2'd1, 0, 2'd0, 32'hFFFFFFFF, 6'd32, "R2");
    push(2'd1, 0, 2'd0, 32'hFFFFFFFF, 6'd32, "R2");
    push(2'd1, 0, 2'd0, 32'h0000E79E, 6'd16, "R2");
    push(2'd1, 0, 2'd0, 32'hFFFFFFFF, 6'd32, "R2");
    push(2'd1, 0, 2'd0, 32'hFFFFFFFF, 6'd32, "R2");
    push(2'd1, 0, 2'd0, 32'h0, 6'd32, "R2");
    push(2'd1, 0, 2'd0, 32'h0, 6'd32, "R2");
    push(2'd2, 0, 2'd0, 32'h0, 6'd0, "R4");
    if (stop_err == 1 || stop_err == 2) return;
    push(2'd3, 0, 2'd1, 32'h50000000, 6'd0, "R6");
    if (stop_err == 3) return;
    for (int i = 0; i < npolls; i++) push(2'd2, 0, 2'd1, 32'h0, 6'd0, "R7");
    if (stop_err == 4 || stop_err == 5) return;
    push(2'd3, 0, 2'd2, 32'h000000F0, 6'd0, "R8");
    push(2'd2, 1, 2'd3, 32'h0, 6'd0, "R8");
    if (stop_err == 6) return;
    push(2'd3, 0, 2'd2, 32'h00000000, 6'd0, "R9");
    push(2'd3, 1, 2'd0, 32'h00000052, 6'd0, "R9");
  endtask

  // engine model + monitor: pops expected items as requests appear
  initial begin
    req_ready = 0; rsp_valid = 0; rsp_ack = 0; rsp_data = 0;
    forever begin
      @(negedge clk);
      if (req_valid) begin
        logic [42:0] item;
        logic [2:0]  a;
        logic [31:0] d;
        item = pack(req_kind, req_ap, req_addr, req_wdata, req_nbits);
        repeat (hold_cycles) @(negedge clk);
        check(pack(req_kind, req_ap, req_addr, req_wdata, req_nbits) == item,
              "R3 hold", pack(req_kind, req_ap, req_addr, req_wdata, req_nbits), item);
        req_ready = 1;
        @(negedge clk);
        req_ready = 0;
        check(!req_valid, "R3 outstanding", {42'd0, req_valid}, 43'd0);
        if (exp_q.size() == 0) begin
          check(0, "R10 extra request", item, 43'd0);
        end else begin
          logic [42:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(item == e, t, item, e);
        end
        a = 3'b000; d = 32'h0;
        case (item[42:41])
          2'd2: begin
            if (!item[40] && item[39:38] == 2'd0) begin a = id_ack; d = id_val; end
            else if (!item[40]) begin
              a = poll_ack;
              d = (poll_seen >= good_after) ? 32'hF0000000 : 32'h50000000;
              poll_seen++;
            end else begin a = ap_ack; d = idr_val; end
          end
          2'd3: begin
            if (item[40]) a = csw_ack;
            else if (item[39:38] == 2'd1) a = pwr_ack;
            else a = 3'b001;
          end
          default: begin a = 3'b111; d = 32'hDEADBEEF; end // R11: raw acks not checked
        endcase
        @(negedge clk);
        rsp_valid = 1; rsp_ack = a; rsp_data = d;
        @(negedge clk);
        rsp_valid = 0; rsp_ack = 0; rsp_data = 0;
      end
    end
  end

  task automatic defaults();
    id_ack = 3'b001; id_val = 32'h2BA01477;
    pwr_ack = 3'b001; poll_ack = 3'b001; ap_ack = 3'b001; csw_ack = 3'b001;
    idr_val = 32'h24770011; good_after = 0; poll_seen = 0;
  endtask

  task automatic run(int exp_err, int npolls, bit mid_start, string tag);
    int n;
    build(exp_err, npolls);
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    if (mid_start) begin
      repeat (15) @(negedge clk);
      start = 1;
      @(negedge clk); start = 0;
    end
    n = 0;
    while (!done && n < 5000) begin @(negedge clk); n++; end
    check(done, {tag, " done"}, {42'd0, done}, 43'd1);
    check(err_code == 3'(exp_err), tag, {40'd0, err_code}, 43'(exp_err));
    repeat (8) @(negedge clk);
    check(done && err_code == 3'(exp_err) && !req_valid, "R10 hold",
          {40'd0, err_code}, 43'(exp_err));
    check(exp_q.size() == 0, {tag, " stream complete"}, 43'(exp_q.size()), 43'd0);
    exp_q.delete(); tag_q.delete();
    poll_seen = 0;
  endtask

  initial begin
    start = 0; rst_n = 0; hold_cycles = 0;
    defaults();
    repeat (3) @(negedge clk);
    check(!busy && !done && !req_valid && err_code == 0, "R1 reset",
          {39'd0, busy, done, req_valid, |err_code}, 43'd0);
    rst_n = 1;
    @(negedge clk);
    check(!busy && !done && !req_valid, "R1 idle", {40'd0, busy, done, req_valid}, 43'd0);

    run(0, 1, 0, "R9 pass");
    hold_cycles = 2;
    run(0, 1, 1, "R10 rerun and ignored start");
    hold_cycles = 0;
    defaults(); good_after = 3; run(0, 4, 0, "R7 fourth poll");
    defaults(); good_after = 4; run(5, 4, 0, "R7 timeout");
    defaults(); poll_ack = 3'b100; run(4, 1, 0, "R7 poll fault");
    defaults(); id_ack = 3'b010; run(1, 0, 0, "R4 no target");
    defaults(); id_ack = 3'b111; run(1, 0, 0, "R4 bad ack");
    defaults(); id_val = 32'h2BB01477; run(2, 0, 0, "R5 wrong part");
    defaults(); id_val = 32'h2BA01476; run(2, 0, 0, "R5 bit0");
    defaults(); pwr_ack = 3'b100; run(3, 0, 0, "R6 write fault");
    defaults(); idr_val = 32'h24770014; run(6, 1, 0, "R8 type");
    defaults(); ap_ack = 3'b010; run(6, 1, 0, "R8 read fail");
    defaults(); csw_ack = 3'b100; run(7, 1, 0, "R9 write fail");
    defaults(); run(0, 1, 0, "R11 final pass");

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule